// File: doc/BRIEF.md
# Transmit Packet FIFO with Space-Threshold Ready

This block is a per-port transmit packet buffer. A host loads it one 64-bit word per write cycle, usually in bursts. The MAC side drains it one word per cycle through a valid/ready handshake.

Each stored word carries sideband tags next to its data:
- packet start and packet end marks;
- a count of valid bytes;
- an as-is tag, meaning no padding or CRC append and no CRC check;
- an error tag, meaning the last byte goes out with an error indication and any appended CRC is spoiled.

The host learns that it may start a burst from a ready flag. The flag is raised only when the free space in the FIFO is at or above a programmable threshold. The flag reaches its output only while an active-low status-enable input is asserted. It drops at once when the bus selects this port for a transfer.

The write side keeps track of an open packet (start seen, end not yet seen):
- A word that arrives outside an open packet is dropped unless it starts one.
- A new start mark while a packet is open closes the old packet with the error tag.
- An optional single-packet mode refuses a new start until the FIFO is fully drained.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid` is 0. The free space equals DEPTH, so `rdy_o` is 1 whenever `stat_en_n` is 0, the port is not selected, and `cfg_thresh` <= DEPTH.
- R2: `rdy_o` is 1 exactly when `stat_en_n`=0, free space (DEPTH minus stored words) >= `cfg_thresh`, and the port is not selected. Free space reflects a push or pop from the cycle after that push or pop.
- R3: While `stat_en_n` is 1, `rdy_o` is held at 0 regardless of free space.
- R4: While `sel_n`=0 and `sel_port` equals the PORT_ID parameter, `rdy_o` is 0 in the same cycle. Selecting a different port has no effect on `rdy_o`.
- R5: Accepted words leave in write order, with data, `nbytes` and the sop/eop marks unchanged. `nbytes` encodes the valid byte count minus one, so 0 means 1 byte and 7 means 8 bytes.
- R6: If `wr_asis`=1 on the sop word, or `cfg_nocrc`=1 at that time, every word of that packet is output with `rd_asis`=1. Otherwise every word is output with `rd_asis`=0.
- R7: `wr_err`=1 on an eop word sets `rd_err` on that word. `wr_err` on a word without eop is ignored.
- R8: A write without sop while no packet is open is discarded.
- R9: An accepted sop while a packet is open starts a new packet. If the last word of the open packet is still stored and is not being read in that cycle, that word is re-tagged with eop=1 and err=1.
- R10: A write while DEPTH words are stored is discarded.
- R11: With `cfg_single`=1, a sop write is discarded while any word is stored.
- R12: `rd_valid` is 1 whenever a word is stored. While `rd_ready` is 0 the presented word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 64 | Host write data |
| wr_nbytes | input | 3 | Valid byte count minus one |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| wr_asis | input | 1 | Send packet as-is (taken with sop) |
| wr_err | input | 1 | Mark packet errored (taken with eop) |
| cfg_thresh | input | $clog2(DEPTH)+1 | Free-space threshold for ready |
| cfg_nocrc | input | 1 | Global as-is for every packet |
| cfg_single | input | 1 | Single-packet mode |
| stat_en_n | input | 1 | Active-low enable of the ready output |
| sel_n | input | 1 | Active-low transfer select |
| sel_port | input | PSEL_W | Port addressed by the select |
| rdy_o | output | 1 | Space-available flag |
| rd_valid | output | 1 | A word is presented to the MAC |
| rd_ready | input | 1 | MAC takes the presented word |
| rd_data | output | 64 | Presented data |
| rd_nbytes | output | 3 | Presented valid byte count minus one |
| rd_sop | output | 1 | Presented word starts a packet |
| rd_eop | output | 1 | Presented word ends a packet |
| rd_asis | output | 1 | Packet is to be sent as-is |
| rd_err | output | 1 | Packet is to be sent with an error |

## Verification
Two kinds of wrong internal state show up at the ports, each at a different time.

- **Wrong word count.** A miscounted fill level changes `rdy_o` in the very next cycle, at the exact threshold edge. It also makes `rd_valid` drop early or linger after a drain.
- **Wrong open-packet or as-is state.** A bad open-packet flag or as-is latch stays hidden until the affected words reach the read side. There it appears as an extra word, a missing word, or a wrong sop/eop/asis/err tag.

The scoreboard compares every word read out against a model built from the requirements. This catches tag errors on the first word that carries one.

// File: rtl/tx_pfifo_pkg.sv
// Shared types for the transmit packet FIFO.
// Assumes a fixed 64-bit data path and a 3-bit byte count.
package tx_pfifo_pkg;
    localparam int TXW_DATA_W = 64;
    localparam int TXW_BCNT_W = 3;

    // One stored word with its sideband tags.
    typedef struct packed {
        logic [TXW_DATA_W-1:0] data;
        logic [TXW_BCNT_W-1:0] nbytes;
        logic                  sop;
        logic                  eop;
        logic                  asis;
        logic                  err;
    } txw_t;
endpackage

// File: rtl/tx_pfifo_store.sv
// Word storage with read/write pointers and a fill count.
// Also re-tags the last written word (eop+err) on request.
// Assumes DEPTH is a power of two and that push is never asserted when full.
module tx_pfifo_store
    import tx_pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  txw_t        push_word,
    input  logic        patch,
    input  logic        pop,
    output txw_t        head_word,
    output logic [AW:0] count,
    output logic        full,
    output logic        empty
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    txw_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write new words and re-tag the previous word on an abort.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
        if (patch) begin
            mem[wr_ptr - 1'b1].eop <= 1'b1;
            mem[wr_ptr - 1'b1].err <= 1'b1;
        end
    end

    // Advance pointers and track how many words are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assign head_word = mem[rd_ptr];
    assign full      = (count == FULL_CNT);
    assign empty     = (count == '0);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> count == $past(count) + 1'b1);
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> count == $past(count) - 1'b1);
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop && !patch) |=> $stable(head_word));
endmodule

// File: rtl/tx_pfifo_admit.sv
// Write-side admission: tracks the open packet and latches the as-is tag.
// Forms the stored word and raises the abort re-tag request.
// Assumes the store reports its fill count and full flag for this cycle.
module tx_pfifo_admit
    import tx_pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TXW_DATA_W-1:0] wr_data,
    input  logic [TXW_BCNT_W-1:0] wr_nbytes,
    input  logic                  wr_sop,
    input  logic                  wr_eop,
    input  logic                  wr_asis,
    input  logic                  wr_err,
    input  logic                  cfg_nocrc,
    input  logic                  cfg_single,
    input  logic [AW:0]           count,
    input  logic                  full,
    input  logic                  pop,
    output logic                  push,
    output txw_t                  push_word,
    output logic                  patch
);
    logic open_q;
    logic asis_q;
    logic sop_ok;
    logic asis_now;

    // Decide whether this write is taken and what tags it carries.
    always_comb begin
        sop_ok    = !(cfg_single && (count != '0));
        push      = wr_en && !full && (wr_sop ? sop_ok : open_q);
        asis_now  = wr_sop ? (wr_asis || cfg_nocrc) : asis_q;
        push_word = '{data: wr_data, nbytes: wr_nbytes, sop: wr_sop,
                      eop: wr_eop, asis: asis_now, err: wr_eop && wr_err};
        patch     = push && wr_sop && open_q && (count > (AW+1)'(pop));
    end

    // Remember whether a packet is open and its as-is tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            asis_q <= 1'b0;
        end else if (push) begin
            open_q <= !wr_eop;
            if (wr_sop) asis_q <= asis_now;
        end
    end

    a_r11_single_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_sop && cfg_single) |-> (count == '0));
    a_r8_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sop && !open_q) |-> !push);
endmodule

// File: rtl/tx_pfifo_status.sv
// Space-threshold ready flag, gated by the status enable and the port select.
// Assumes count is the registered fill level of the store.
module tx_pfifo_status #(
    parameter int DEPTH   = 256,
    parameter int PSEL_W  = 2,
    parameter int PORT_ID = 0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       count,
    input  logic [AW:0]       cfg_thresh,
    input  logic              stat_en_n,
    input  logic              sel_n,
    input  logic [PSEL_W-1:0] sel_port,
    output logic              rdy_o
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [AW:0] free_cnt;
    logic        selected;

    // Compare free space with the threshold and apply the gates.
    always_comb begin
        free_cnt = FULL_CNT - count;
        selected = !sel_n && (sel_port == PSEL_W'(PORT_ID));
        rdy_o    = !stat_en_n && !selected && (free_cnt >= cfg_thresh);
    end

    a_r2_space: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> ((FULL_CNT - count) >= cfg_thresh));
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en_n |-> !rdy_o);
endmodule

// File: rtl/tx_pkt_fifo.sv
// Top of the per-port transmit packet FIFO: wires admission, storage and status.
// Assumes DEPTH is a power of two; the read side pops on rd_valid && rd_ready.
module tx_pkt_fifo
    import tx_pfifo_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int PSEL_W  = 2,
    parameter int PORT_ID = 0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TXW_DATA_W-1:0] wr_data,
    input  logic [TXW_BCNT_W-1:0] wr_nbytes,
    input  logic                  wr_sop,
    input  logic                  wr_eop,
    input  logic                  wr_asis,
    input  logic                  wr_err,
    input  logic [AW:0]           cfg_thresh,
    input  logic                  cfg_nocrc,
    input  logic                  cfg_single,
    input  logic                  stat_en_n,
    input  logic                  sel_n,
    input  logic [PSEL_W-1:0]     sel_port,
    output logic                  rdy_o,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic [TXW_DATA_W-1:0] rd_data,
    output logic [TXW_BCNT_W-1:0] rd_nbytes,
    output logic                  rd_sop,
    output logic                  rd_eop,
    output logic                  rd_asis,
    output logic                  rd_err
);
    txw_t        push_word;
    txw_t        head_word;
    logic        push;
    logic        patch;
    logic        pop;
    logic [AW:0] count;
    logic        full;
    logic        empty;

    assign rd_valid = !empty;
    assign pop      = rd_valid && rd_ready;

    tx_pfifo_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_nbytes(wr_nbytes), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_asis(wr_asis), .wr_err(wr_err), .cfg_nocrc(cfg_nocrc),
        .cfg_single(cfg_single), .count(count), .full(full), .pop(pop),
        .push(push), .push_word(push_word), .patch(patch)
    );

    tx_pfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
        .patch(patch), .pop(pop), .head_word(head_word), .count(count),
        .full(full), .empty(empty)
    );

    tx_pfifo_status #(.DEPTH(DEPTH), .PSEL_W(PSEL_W), .PORT_ID(PORT_ID)) u_status (
        .clk(clk), .rst_n(rst_n), .count(count), .cfg_thresh(cfg_thresh),
        .stat_en_n(stat_en_n), .sel_n(sel_n), .sel_port(sel_port), .rdy_o(rdy_o)
    );

    assign rd_data   = head_word.data;
    assign rd_nbytes = head_word.nbytes;
    assign rd_sop    = head_word.sop;
    assign rd_eop    = head_word.eop;
    assign rd_asis   = head_word.asis;
    assign rd_err    = head_word.err;
endmodule

// File: tb/tx_pkt_fifo_bench.sv
// Scoreboard bench: the write task predicts accepted words into a queue;
// a monitor compares every word handed to the MAC side.
module tx_pkt_fifo_bench;
    localparam int DEPTH = 16;
    localparam int PSEL_W = 2;
    localparam int PORT_ID = 2;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_sop = 0, wr_eop = 0, wr_asis = 0, wr_err = 0;
    logic [63:0] wr_data = '0;
    logic [2:0] wr_nbytes = '0;
    logic [AW:0] cfg_thresh = '0;
    logic cfg_nocrc = 0, cfg_single = 0;
    logic stat_en_n = 1, sel_n = 1;
    logic [PSEL_W-1:0] sel_port = '0;
    logic rdy_o, rd_valid, rd_sop, rd_eop, rd_asis, rd_err;
    logic rd_ready = 0;
    logic [63:0] rd_data;
    logic [2:0] rd_nbytes;

    int n_cmp = 0;
    int n_bad = 0;
    logic [71:0] exp_q[$];
    logic m_open = 0;
    logic m_asis = 0;

    always #2.5 clk = ~clk;

    tx_pkt_fifo #(.DEPTH(DEPTH), .PSEL_W(PSEL_W), .PORT_ID(PORT_ID)) u_tx_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_nbytes(wr_nbytes), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_asis(wr_asis), .wr_err(wr_err), .cfg_thresh(cfg_thresh),
        .cfg_nocrc(cfg_nocrc), .cfg_single(cfg_single), .stat_en_n(stat_en_n),
        .sel_n(sel_n), .sel_port(sel_port), .rdy_o(rdy_o), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_nbytes(rd_nbytes),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_asis(rd_asis), .rd_err(rd_err)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each handed-over word with the scoreboard front.
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            logic [71:0] act;
            act = {rd_data, rd_nbytes, rd_sop, rd_eop, rd_asis, rd_err};
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8 unexpected word", act, '0);
            end else begin
                logic [71:0] e;
                e = exp_q.pop_front();
                check(act == e, "R5/R6/R7/R9 word", act, e);
            end
        end
    end

    // Driver: apply one write for one cycle and predict its effect.
    task automatic wr(input logic [63:0] d, input logic [2:0] n, input logic s,
                      input logic e, input logic a, input logic er);
        logic take;
        logic asis_v;
        take = 1'b0;
        if (exp_q.size() < DEPTH) begin
            if (s) take = !(cfg_single && exp_q.size() != 0);
            else   take = m_open;
        end
        if (take) begin
            asis_v = s ? (a | cfg_nocrc) : m_asis;
            if (s && m_open && exp_q.size() > 0) begin
                logic [71:0] t;
                t = exp_q[exp_q.size()-1];
                t[2] = 1'b1;
                t[0] = 1'b1;
                exp_q[exp_q.size()-1] = t;
            end
            if (s) m_asis = asis_v;
            m_open = !e;
            exp_q.push_back({d, n, s, e, asis_v, e & er});
        end
        wr_en = 1; wr_data = d; wr_nbytes = n; wr_sop = s;
        wr_eop = e; wr_asis = a; wr_err = er;
        @(posedge clk); #1;
        wr_en = 0; wr_sop = 0; wr_eop = 0; wr_asis = 0; wr_err = 0;
    endtask

    // Read everything out, then confirm nothing is left.
    task automatic drain(input string tag);
        rd_ready = 1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (!rd_valid) break;
        end
        rd_ready = 0;
        check(exp_q.size() == 0 && !rd_valid, tag, 72'(exp_q.size()), '0);
    endtask

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1 / R3: empty after reset, ready gated off
        check(!rd_valid, "R1 rd_valid after reset", 72'(rd_valid), 0);
        check(!rdy_o, "R3 gated ready", 72'(rdy_o), 0);
        stat_en_n = 0; cfg_thresh = 4; #1;
        check(rdy_o, "R1 ready with full space", 72'(rdy_o), 1);
        // R4: selecting this port drops ready, another port does not
        sel_n = 0; sel_port = 2'(PORT_ID); #1;
        check(!rdy_o, "R4 select own port", 72'(rdy_o), 0);
        sel_port = 2'(PORT_ID + 1); #1;
        check(rdy_o, "R4 select other port", 72'(rdy_o), 1);
        sel_n = 1;
        @(posedge clk); #1;
        // R5 R6 R7: as-is on sop, err on eop, err off eop ignored
        wr(64'h1111_0000_0000_0001, 3'd7, 1, 0, 1, 1);
        wr(64'h1111_0000_0000_0002, 3'd7, 0, 0, 0, 0);
        wr(64'h1111_0000_0000_0003, 3'd2, 0, 1, 0, 1);
        drain("R5 drain packet A");
        // R6: global as-is
        cfg_nocrc = 1;
        wr(64'h2222_0000_0000_0001, 3'd0, 1, 0, 0, 0);
        wr(64'h2222_0000_0000_0002, 3'd5, 0, 1, 0, 0);
        cfg_nocrc = 0;
        drain("R6 drain packet B");
        // R8: orphan word discarded
        wr(64'h3333_0000_0000_0009, 3'd7, 0, 1, 0, 0);
        check(!rd_valid, "R8 orphan discarded", 72'(rd_valid), 0);
        // R9: sop while open re-tags the last stored word
        wr(64'h4444_0000_0000_0001, 3'd7, 1, 0, 0, 0);
        wr(64'h4444_0000_0000_0002, 3'd7, 0, 0, 0, 0);
        wr(64'h4444_0000_0000_0003, 3'd7, 1, 0, 0, 0);
        wr(64'h4444_0000_0000_0004, 3'd3, 0, 1, 0, 0);
        drain("R9 drain aborted packet");
        // R2: threshold edge, count visible a cycle after the push
        wr(64'h5555_0000_0000_0000, 3'd7, 1, 0, 0, 0);
        for (int i = 1; i < 12; i++) wr(64'h5555_0000_0000_0000 | 64'(i), 3'd7, 0, 0, 0, 0);
        #1 check(rdy_o, "R2 free equals threshold", 72'(rdy_o), 1);
        wr(64'h5555_0000_0000_000c, 3'd7, 0, 0, 0, 0);
        #1 check(!rdy_o, "R2 free below threshold", 72'(rdy_o), 0);
        // R10: fill, then overflow write is dropped
        for (int i = 13; i < 16; i++) wr(64'h5555_0000_0000_0000 | 64'(i), 3'd7, 0, 0, 0, 0);
        wr(64'h5555_0000_0000_00ff, 3'd1, 0, 1, 0, 0);
        // R12: head word stays while the MAC stalls
        repeat (2) @(posedge clk);
        #1 check(rd_valid && {rd_data, rd_nbytes, rd_sop, rd_eop, rd_asis, rd_err} == exp_q[0],
                 "R12 stalled head", {rd_data, rd_nbytes, rd_sop, rd_eop, rd_asis, rd_err}, exp_q[0]);
        drain("R10 drain full FIFO");
        // R11: single-packet mode refuses a second sop
        cfg_single = 1;
        wr(64'h6666_0000_0000_0001, 3'd7, 1, 0, 0, 0);
        wr(64'h6666_0000_0000_0002, 3'd4, 0, 1, 0, 0);
        wr(64'h7777_0000_0000_0001, 3'd7, 1, 0, 0, 0);
        wr(64'h7777_0000_0000_0002, 3'd4, 0, 1, 0, 0);
        drain("R11 second packet refused");
        wr(64'h8888_0000_0000_0001, 3'd7, 1, 1, 0, 0);
        drain("R11 sop after drain");
        cfg_single = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule